// File: doc/BRIEF.md
# ModR/M and SIB Address Generator

This block decodes the operand-addressing bytes of a 64-bit-mode instruction. It takes the ModR/M byte, the optional SIB byte and the four REX extension bits. From these it forms the 4-bit register operand numbers and, for memory operands, the 64-bit effective address. The address is base + index × scale + displacement, or next-instruction address + displacement for instruction-pointer-relative operands. The block drives the base and index register numbers to two read ports of a 16-entry, 64-bit register file and reads the values back in the same cycle.

A decoder presents one operand description per transfer on a valid/ready handshake. The block registers the decoded result through one pipeline stage. The raw 32-bit displacement field comes in unextended. The block picks the 8-bit or 32-bit form from the mode and sign-extends it. Segment bases, 16-bit addressing and operand fetch are handled elsewhere.

Top module: `modrm_agu`

## Requirements
- R1: When modrm[7:6]=11 the operand is register-direct. isRegDirect=1 and rmReg={rexB,modrm[2:0]}. hasBase, hasIndex and isRipRel are 0, baseReg, indexReg and effAddr are 0, and no displacement is used. In every memory mode isRegDirect=0 and rmReg=0.
- R2: regNum is {rexR,modrm[5:3]} for every input.
- R3: In a memory mode (modrm[7:6] of 00, 01 or 10) with modrm[2:0]≠100, the base is {rexB,modrm[2:0]} and there is no index. Mode 00 adds no displacement, except the R7 case. Mode 01 adds dispRaw[7:0] sign-extended. Mode 10 adds dispRaw sign-extended.
- R4: In a memory mode with modrm[2:0]=100 the SIB byte is used. The base is {rexB,sib[2:0]} and the index is {rexX,sib[5:3]}. The index value is multiplied by 1, 2, 4 or 8 for sib[7:6] = 00, 01, 10 or 11.
- R5: An SIB index number {rexX,sib[5:3]} of 0100 means there is no index (hasIndex=0, indexReg=0, zero index term). Index number 1100 is a real index register.
- R6: With SIB, mode 00 and sib[2:0]=101, there is no base (hasBase=0, baseReg=0). The sign-extended 32-bit displacement is added to the scaled index alone. In modes 01 and 10 the same base code names a real register.
- R7: Mode 00 with modrm[2:0]=101 (no SIB) gives isRipRel=1, hasBase=0, and effAddr = nextIp + sign-extended dispRaw.
- R8: The address sum wraps modulo 2^64.
- R9: An input accepted when inValid and inReady are both 1 appears on the outputs with outValid=1 after the next clock edge. inReady is 1 whenever outValid is 0 or outReady is 1. While outValid=1 and outReady=0, all outputs hold. After reset outValid=0.
- R10: The output wide carries the accepted rexW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input operand description valid |
| inReady | output | 1 | Block can accept an input |
| modrm | input | 8 | ModR/M byte |
| sib | input | 8 | SIB byte (ignored unless used) |
| rexW | input | 1 | REX operand-width bit |
| rexR | input | 1 | REX extension of the reg field |
| rexX | input | 1 | REX extension of the SIB index |
| rexB | input | 1 | REX extension of r/m or SIB base |
| dispRaw | input | 32 | Raw displacement field |
| nextIp | input | 64 | Address of the next instruction |
| rdAddrA | output | 4 | Register file read address, base |
| rdDataA | input | 64 | Register file read data, base |
| rdAddrB | output | 4 | Register file read address, index |
| rdDataB | input | 64 | Register file read data, index |
| outValid | output | 1 | Output result valid |
| outReady | input | 1 | Consumer accepts the result |
| regNum | output | 4 | Register from the reg field |
| isRegDirect | output | 1 | Operand is register-direct |
| rmReg | output | 4 | Register-direct register number |
| hasBase | output | 1 | Address uses a base register |
| baseReg | output | 4 | Base register number |
| hasIndex | output | 1 | Address uses an index register |
| indexReg | output | 4 | Index register number |
| isRipRel | output | 1 | Address is next-instruction relative |
| wide | output | 1 | Registered rexW |
| effAddr | output | 64 | Effective address |

## Verification
A wrong decode of the mode or of the SIB escape shows on the very next output beat. The bench compares the register numbers and the hasBase, hasIndex and isRipRel flags field by field against its own model, so a wrong register number, a lost extension bit or a wrong special case is reported at the result it corrupts. A wrong scale, sign extension or term selection shows only as a wrong effAddr, and only for operands whose register values and displacement make the terms differ. For that reason random register-file contents and displacements are mixed with directed values that make the wrap and the sign visible. A fault in the handshake state shows as an output that changes during backpressure, or as a result that is lost or repeated one beat later.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int REG_BITS = 4;
  localparam int ADDR_BITS = 64;
  localparam int DISP_BITS = 32;

  typedef enum logic [1:0] {DISP_NONE, DISP_8, DISP_32} dispSel_e;

  typedef struct packed {
    logic                regDirect;
    logic                useSib;
    logic                ripRel;
    logic                noBase;
    logic                noIndex;
    dispSel_e            dispSel;
    logic [1:0]          scale;
    logic [REG_BITS-1:0] regNum;
    logic [REG_BITS-1:0] rmNum;
    logic [REG_BITS-1:0] baseNum;
    logic [REG_BITS-1:0] indexNum;
  } ctrlStrobes_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   modrm,
  input  logic [7:0]   sib,
  input  logic         rexR,
  input  logic         rexX,
  input  logic         rexB,
  output ctrlStrobes_t strobes
);
  localparam logic [2:0] SIB_ESC = 3'b100;
  localparam logic [2:0] NO_BASE_CODE = 3'b101;
  localparam logic [REG_BITS-1:0] NO_INDEX_NUM = 4'b0100;

  logic [1:0] modField;
  logic [2:0] rmField;
  logic       isMem;

  assign modField = modrm[7:6];
  assign rmField  = modrm[2:0];
  assign isMem    = (modField != 2'b11);

  always_comb begin
    strobes.regDirect = !isMem;
    strobes.useSib    = isMem && (rmField == SIB_ESC);
    strobes.ripRel    = (modField == 2'b00) && (rmField == NO_BASE_CODE);
    strobes.regNum    = {rexR, modrm[5:3]};
    strobes.rmNum     = {rexB, rmField};
    strobes.scale     = sib[7:6];
    strobes.indexNum  = {rexX, sib[5:3]};
    strobes.baseNum   = strobes.useSib ? {rexB, sib[2:0]} : {rexB, rmField};
    strobes.noBase    = strobes.ripRel ||
                        (strobes.useSib && modField == 2'b00 && sib[2:0] == NO_BASE_CODE);
    strobes.noIndex   = !strobes.useSib || (strobes.indexNum == NO_INDEX_NUM);
    unique case (modField)
      2'b01:   strobes.dispSel = DISP_8;
      2'b10:   strobes.dispSel = DISP_32;
      2'b00:   strobes.dispSel = strobes.noBase ? DISP_32 : DISP_NONE;
      default: strobes.dispSel = DISP_NONE;
    endcase
  end

  // R6 / R7: a missing base always comes with a 32-bit displacement
  assert_nobase_disp_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.noBase |-> strobes.dispSel == DISP_32);

  // R1: register-direct never escapes to SIB or next-instruction addressing
  assert_direct_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regDirect |-> (!strobes.useSib && !strobes.ripRel && strobes.dispSel == DISP_NONE));
endmodule

// File: rtl/agu_dp.sv
module agu_dp
  import agu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [DISP_BITS-1:0] dispRaw,
  input  logic [ADDR_BITS-1:0] nextIp,
  input  logic                 rexW,
  input  logic                 inValid,
  output logic                 inReady,
  output logic [REG_BITS-1:0]  rdAddrA,
  input  logic [ADDR_BITS-1:0] rdDataA,
  output logic [REG_BITS-1:0]  rdAddrB,
  input  logic [ADDR_BITS-1:0] rdDataB,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [REG_BITS-1:0]  regNum,
  output logic                 isRegDirect,
  output logic [REG_BITS-1:0]  rmReg,
  output logic                 hasBase,
  output logic [REG_BITS-1:0]  baseReg,
  output logic                 hasIndex,
  output logic [REG_BITS-1:0]  indexReg,
  output logic                 isRipRel,
  output logic                 wide,
  output logic [ADDR_BITS-1:0] effAddr
);
  logic [ADDR_BITS-1:0] baseTerm, indexTerm, dispTerm, sumAddr;
  logic                 load;

  assign rdAddrA = strobes.baseNum;
  assign rdAddrB = strobes.indexNum;
  assign inReady = !outValid || outReady;
  assign load    = inValid && inReady;

  always_comb begin
    if (strobes.ripRel)       baseTerm = nextIp;
    else if (strobes.noBase)  baseTerm = '0;
    else                      baseTerm = rdDataA;
    indexTerm = strobes.noIndex ? '0 : (rdDataB << strobes.scale);
    unique case (strobes.dispSel)
      DISP_8:  dispTerm = {{(ADDR_BITS-8){dispRaw[7]}}, dispRaw[7:0]};
      DISP_32: dispTerm = {{(ADDR_BITS-DISP_BITS){dispRaw[DISP_BITS-1]}}, dispRaw};
      default: dispTerm = '0;
    endcase
    sumAddr = baseTerm + indexTerm + dispTerm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      regNum      <= '0;
      isRegDirect <= 1'b0;
      rmReg       <= '0;
      hasBase     <= 1'b0;
      baseReg     <= '0;
      hasIndex    <= 1'b0;
      indexReg    <= '0;
      isRipRel    <= 1'b0;
      wide        <= 1'b0;
      effAddr     <= '0;
    end else begin
      if (load) begin
        regNum      <= strobes.regNum;
        isRegDirect <= strobes.regDirect;
        rmReg       <= strobes.regDirect ? strobes.rmNum : '0;
        hasBase     <= !strobes.regDirect && !strobes.noBase;
        baseReg     <= (strobes.regDirect || strobes.noBase) ? '0 : strobes.baseNum;
        hasIndex    <= !strobes.regDirect && !strobes.noIndex;
        indexReg    <= (strobes.regDirect || strobes.noIndex) ? '0 : strobes.indexNum;
        isRipRel    <= strobes.ripRel;
        wide        <= rexW;
        effAddr     <= strobes.regDirect ? '0 : sumAddr;
      end
      if (load)          outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(effAddr) && $stable(regNum) && $stable(baseReg)));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  assert_direct_noaddr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isRegDirect) |-> (effAddr == '0 && !hasBase && !hasIndex && !isRipRel));
endmodule

// File: rtl/modrm_agu.sv
module modrm_agu
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  modrm,
  input  logic [7:0]  sib,
  input  logic        rexW,
  input  logic        rexR,
  input  logic        rexX,
  input  logic        rexB,
  input  logic [31:0] dispRaw,
  input  logic [63:0] nextIp,
  output logic [3:0]  rdAddrA,
  input  logic [63:0] rdDataA,
  output logic [3:0]  rdAddrB,
  input  logic [63:0] rdDataB,
  output logic        outValid,
  input  logic        outReady,
  output logic [3:0]  regNum,
  output logic        isRegDirect,
  output logic [3:0]  rmReg,
  output logic        hasBase,
  output logic [3:0]  baseReg,
  output logic        hasIndex,
  output logic [3:0]  indexReg,
  output logic        isRipRel,
  output logic        wide,
  output logic [63:0] effAddr
);
  ctrlStrobes_t strobes;

  agu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modrm(modrm), .sib(sib),
    .rexR(rexR), .rexX(rexX), .rexB(rexB), .strobes(strobes)
  );

  agu_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dispRaw(dispRaw), .nextIp(nextIp),
    .rexW(rexW), .inValid(inValid), .inReady(inReady),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .outValid(outValid), .outReady(outReady), .regNum(regNum),
    .isRegDirect(isRegDirect), .rmReg(rmReg), .hasBase(hasBase), .baseReg(baseReg),
    .hasIndex(hasIndex), .indexReg(indexReg), .isRipRel(isRipRel), .wide(wide),
    .effAddr(effAddr)
  );
endmodule

// File: tb/sim_modrm_agu.sv
`timescale 1ns/1ps
module sim_modrm_agu;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b1;
  logic [7:0] modrm = '0, sib = '0;
  logic rexW = 0, rexR = 0, rexX = 0, rexB = 0;
  logic [31:0] dispRaw = '0;
  logic [63:0] nextIp = '0;
  logic inReady, outValid, isRegDirect, hasBase, hasIndex, isRipRel, wide;
  logic [3:0] rdAddrA, rdAddrB, regNum, rmReg, baseReg, indexReg;
  logic [63:0] rdDataA, rdDataB, effAddr;
  logic [63:0] rf [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign rdDataA = rf[rdAddrA];
  assign rdDataB = rf[rdAddrB];

  modrm_agu u0 (.*);

  typedef struct {
    logic [3:0] regNum, rmReg, baseReg, indexReg;
    logic isRegDirect, hasBase, hasIndex, isRipRel, wide;
    logic [63:0] addr;
  } exp_t;

  function automatic exp_t model();
    exp_t e;
    logic [1:0] md = modrm[7:6];
    logic [2:0] rm = modrm[2:0];
    logic [63:0] d8 = {{56{dispRaw[7]}}, dispRaw[7:0]};
    logic [63:0] d32 = {{32{dispRaw[31]}}, dispRaw};
    logic [63:0] disp;
    logic [3:0] ix;
    e.regNum = {rexR, modrm[5:3]};
    e.wide = rexW;
    e.rmReg = 0; e.baseReg = 0; e.indexReg = 0;
    e.isRegDirect = 0; e.hasBase = 0; e.hasIndex = 0; e.isRipRel = 0; e.addr = 0;
    disp = (md == 2'd1) ? d8 : (md == 2'd2) ? d32 : 64'd0;
    if (md == 2'd3) begin
      e.isRegDirect = 1; e.rmReg = {rexB, rm};
    end else if (rm == 3'd4) begin
      ix = {rexX, sib[5:3]};
      if (ix != 4'd4) begin
        e.hasIndex = 1; e.indexReg = ix; e.addr = rf[ix] << sib[7:6];
      end
      if (md == 2'd0 && sib[2:0] == 3'd5) e.addr = e.addr + d32;
      else begin
        e.hasBase = 1; e.baseReg = {rexB, sib[2:0]};
        e.addr = e.addr + rf[{rexB, sib[2:0]}] + disp;
      end
    end else if (md == 2'd0 && rm == 3'd5) begin
      e.isRipRel = 1; e.addr = nextIp + d32;
    end else begin
      e.hasBase = 1; e.baseReg = {rexB, rm};
      e.addr = rf[{rexB, rm}] + disp;
    end
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(exp_t e);
    string tag;
    if (e.isRegDirect) tag = "R1";
    else if (e.isRipRel) tag = "R7";
    else if (modrm[2:0] == 3'd4) tag = "R4";
    else tag = "R3";
    chk("R9 outValid", {63'd0, outValid}, 64'd1);
    chk("R2 regNum", {60'd0, regNum}, {60'd0, e.regNum});
    chk("R10 wide", {63'd0, wide}, {63'd0, e.wide});
    chk({tag, " fields"},
        {40'd0, isRegDirect, rmReg, hasBase, baseReg, hasIndex, indexReg, isRipRel},
        {40'd0, e.isRegDirect, e.rmReg, e.hasBase, e.baseReg, e.hasIndex, e.indexReg, e.isRipRel});
    chk({tag, " effAddr"}, effAddr, e.addr);
  endtask

  task automatic send(logic [7:0] m, logic [7:0] s, logic [3:0] rex, logic [31:0] d, logic [63:0] ip);
    exp_t e;
    @(negedge clk);
    modrm = m; sib = s; {rexW, rexR, rexX, rexB} = rex; dispRaw = d; nextIp = ip;
    inValid = 1; outReady = 1;
    e = model();
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    checkAll(e);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) rf[i] = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset outValid", {63'd0, outValid}, 64'd0);
    chk("R9 reset inReady", {63'd0, inReady}, 64'd1);
    rstN = 1;

    // R1 register-direct, extension on r/m
    send(8'hE5, 8'hFF, 4'b1101, 32'h1234_5678, 64'h10);
    // R6 SIB no base, no index: address is disp alone
    send(8'h04, 8'h25, 4'b0000, 32'h0000_000A, 64'h0);
    // R6 negative disp32 with scaled index, no base
    rf[1] = 64'h100;
    send(8'h04, 8'hCD, 4'b0000, 32'hFFFF_FFF0, 64'h0);
    // R5 REX.X set: index 1100 is a real register
    rf[12] = 64'h40;
    send(8'h44, 8'h60, 4'b0010, 32'h0, 64'h0);
    // R6 base code 101 in mode 01 is a real base
    send(8'h44, 8'h25, 4'b0001, 32'h7F, 64'h0);
    // R8 wrap: base 0x10 plus disp8 -16 gives 0
    rf[3] = 64'h10;
    send(8'h43, 8'h00, 4'b0000, 32'h0000_00F0, 64'h0);
    rf[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    send(8'h83, 8'h00, 4'b0000, 32'h0000_0002, 64'h0);
    // R7 next-instruction relative
    send(8'h05, 8'h00, 4'b0000, 32'h8000_0000, 64'h0000_0001_0000_0000);
    // R3 mode 00, no disp used though field nonzero
    send(8'h02, 8'h00, 4'b0001, 32'hDEAD_BEEF, 64'h0);

    // R9 backpressure: result holds, second accepted after release
    begin
      exp_t e1, e2;
      @(negedge clk);
      modrm = 8'h80; sib = 0; {rexW, rexR, rexX, rexB} = 4'b1000; dispRaw = 32'h100; inValid = 1; outReady = 0;
      e1 = model();
      @(posedge clk); @(negedge clk);
      chk("R9 stall inReady", {63'd0, inReady}, 64'd0);
      modrm = 8'h4B; dispRaw = 32'h5; {rexW, rexR, rexX, rexB} = 4'b0100;
      e2 = model();
      @(posedge clk); @(negedge clk);
      chk("R9 hold effAddr", effAddr, e1.addr);
      chk("R9 hold regNum", {60'd0, regNum}, {60'd0, e1.regNum});
      outReady = 1;
      @(posedge clk); @(negedge clk);
      inValid = 0;
      checkAll(e2);
      @(posedge clk); @(negedge clk);
      chk("R9 drain outValid", {63'd0, outValid}, 64'd0);
    end

    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) for (int j = 0; j < 16; j++) rf[j] = {$urandom, $urandom};
      send($urandom, $urandom, $urandom, $urandom, {$urandom, $urandom});
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule